// File: doc/BRIEF.md
# Single-Error-Correcting 7/4 Codec

This block protects a 4-bit value with three check bits, so that any single flipped bit in the 7-bit word can be repaired. The encoder builds a systematic word: the four information bits go out unchanged in the upper positions and the three even-parity check bits follow. The decoder recomputes the parity sums over a received word to form a 3-bit syndrome. It raises an error flag when the syndrome is non-zero and flips the one information bit that the syndrome names before handing the 4 data bits on.

Both paths are pure combinational logic. A build-time switch either places one register stage on all outputs, with each path's valid strobe delayed by the same cycle, or passes the results straight through. In registered mode the output registers load only when the matching input strobe is high.

Top module: `sec74_codec`

## Requirements
- R1: The encoded word places the information bits first: enc_word[6:3] equals enc_data[3:0], with bit 3 of the data at word bit 6.
- R2: enc_word[2] is the even parity of data bits 3, 2 and 1.
- R3: enc_word[1] is the even parity of data bits 3, 2 and 0.
- R4: enc_word[0] is the even parity of data bits 3, 1 and 0.
- R5: A received word that is a valid codeword yields syndrome 000, a low error flag and data equal to dec_word[6:3].
- R6: A single flip in check positions 0, 1 or 2 yields syndrome 001, 010 or 100, raises the error flag, and leaves dec_data equal to the original information bits.
- R7: A single flip in word bit 3, 4, 5 or 6 yields syndrome 011, 101, 110 or 111 respectively, raises the error flag, and dec_data returns the original information bits.
- R8: With the register stage enabled (default), each output valid is high exactly one clock after the matching input valid was high, and the results of that input appear in the same cycle.
- R9: A synchronous active-high reset drives both output valids, both data outputs, the error flag and the syndrome to zero.
- R10: With the register stage enabled, a cycle with an input valid low leaves that path's data outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst | input | 1 | Synchronous active-high reset |
| enc_vi | input | 1 | Encoder input strobe |
| enc_data | input | 4 | Information bits to encode |
| enc_vo | output | 1 | Encoder output strobe |
| enc_word | output | 7 | Systematic codeword {data, check bits} |
| dec_vi | input | 1 | Decoder input strobe |
| dec_word | input | 7 | Received word to check and repair |
| dec_vo | output | 1 | Decoder output strobe |
| dec_data | output | 4 | Repaired information bits |
| dec_err | output | 1 | High when the syndrome is non-zero |
| dec_syn | output | 3 | Syndrome of the received word |

## Verification
The checker takes the inputs to be known values that change only between clock edges, and it trusts the repair claim only for words carrying at most one flipped bit; a double flip would give a syndrome naming a wrong position. The stimulus therefore drives every input on the falling edge and only ever feeds the decoder clean codewords or codewords with exactly one bit inverted, sweeping all sixteen data values against all seven flip positions.

// File: rtl/sec74_pkg.sv
package sec74_pkg;
  localparam int INFO_W = 4;
  localparam int CHK_W  = 3;
  localparam int WORD_W = INFO_W + CHK_W;

  typedef logic [INFO_W-1:0] info_t;
  typedef logic [CHK_W-1:0]  syn_t;
  typedef logic [WORD_W-1:0] word_t;

  // Syndrome that names word position p; check bits carry a single one,
  // information bits carry the check sums that cover them.
  function automatic syn_t pos_code(input int p);
    syn_t c;
    c = '0;
    if (p < CHK_W) begin
      c[p] = 1'b1;
    end else begin
      case (p - CHK_W)
        0:       c = 3'b011;
        1:       c = 3'b101;
        2:       c = 3'b110;
        default: c = 3'b111;
      endcase
    end
    return c;
  endfunction

  // Information bits covered by check bit k.
  function automatic info_t cover_mask(input int k);
    info_t m;
    syn_t  c;
    for (int j = 0; j < INFO_W; j++) begin
      c    = pos_code(CHK_W + j);
      m[j] = c[k];
    end
    return m;
  endfunction
endpackage

// File: rtl/sec74_enc.sv
module sec74_enc
  import sec74_pkg::*;
(
  input  info_t data,
  output word_t word
);
  syn_t chk;

  for (genvar k = 0; k < CHK_W; k++) begin : g_chk
    localparam info_t MASK = cover_mask(k);
    assign chk[k] = ^(data & MASK);
  end

  assign word = {data, chk};
endmodule

// File: rtl/sec74_dec.sv
module sec74_dec
  import sec74_pkg::*;
(
  input  word_t rx,
  output info_t data,
  output logic  err,
  output syn_t  syn
);
  info_t rx_info;
  info_t flip;

  assign rx_info = rx[WORD_W-1:CHK_W];

  for (genvar k = 0; k < CHK_W; k++) begin : g_syn
    localparam info_t MASK = cover_mask(k);
    assign syn[k] = rx[k] ^ (^(rx_info & MASK));
  end

  for (genvar j = 0; j < INFO_W; j++) begin : g_fix
    localparam syn_t CODE = pos_code(CHK_W + j);
    assign flip[j] = (syn == CODE);
  end

  assign data = rx_info ^ flip;
  assign err  = |syn;
endmodule

// File: rtl/sec74_codec.sv
module sec74_codec
  import sec74_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enc_vi,
  input  logic [INFO_W-1:0]     enc_data,
  output logic                  enc_vo,
  output logic [WORD_W-1:0]     enc_word,
  input  logic                  dec_vi,
  input  logic [WORD_W-1:0]     dec_word,
  output logic                  dec_vo,
  output logic [INFO_W-1:0]     dec_data,
  output logic                  dec_err,
  output logic [CHK_W-1:0]      dec_syn
);
  word_t enc_w;
  info_t dec_d;
  logic  dec_e;
  syn_t  dec_s;

  sec74_enc u_enc (
    .data (enc_data),
    .word (enc_w)
  );

  sec74_dec u_dec (
    .rx   (dec_word),
    .data (dec_d),
    .err  (dec_e),
    .syn  (dec_s)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        enc_vo   <= 1'b0;
        enc_word <= '0;
      end else begin
        enc_vo <= enc_vi;
        if (enc_vi) enc_word <= enc_w;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        dec_vo   <= 1'b0;
        dec_data <= '0;
        dec_err  <= 1'b0;
        dec_syn  <= '0;
      end else begin
        dec_vo <= dec_vi;
        if (dec_vi) begin
          dec_data <= dec_d;
          dec_err  <= dec_e;
          dec_syn  <= dec_s;
        end
      end
    end
  end else begin : g_comb
    assign enc_vo   = enc_vi;
    assign enc_word = enc_w;
    assign dec_vo   = dec_vi;
    assign dec_data = dec_d;
    assign dec_err  = dec_e;
    assign dec_syn  = dec_s;
  end
endmodule

// File: rtl/sec74_codec_chk.sv
module sec74_codec_chk
  import sec74_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              enc_vi,
  input logic [INFO_W-1:0] enc_data,
  input logic              enc_vo,
  input logic [WORD_W-1:0] enc_word,
  input logic              dec_vi,
  input logic [WORD_W-1:0] dec_word,
  input logic              dec_vo,
  input logic [INFO_W-1:0] dec_data,
  input logic              dec_err,
  input logic [CHK_W-1:0]  dec_syn
);
  // R2
  c2_parity_chk: assert property (@(posedge clk) disable iff (rst)
    enc_vo |-> (enc_word[6] ^ enc_word[5] ^ enc_word[4] ^ enc_word[2]) == 1'b0);
  // R3
  c1_parity_chk: assert property (@(posedge clk) disable iff (rst)
    enc_vo |-> (enc_word[6] ^ enc_word[5] ^ enc_word[3] ^ enc_word[1]) == 1'b0);
  // R4
  c0_parity_chk: assert property (@(posedge clk) disable iff (rst)
    enc_vo |-> (enc_word[6] ^ enc_word[4] ^ enc_word[3] ^ enc_word[0]) == 1'b0);
  // R5
  flag_match_chk: assert property (@(posedge clk) disable iff (rst)
    dec_vo |-> (dec_err == (dec_syn != 3'b000)));

  if (REG_OUT) begin : g_seq
    // R8
    enc_lat_chk: assert property (@(posedge clk) disable iff (rst)
      enc_vi |=> enc_vo);
    // R8
    enc_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !enc_vi |=> !enc_vo);
    // R8
    dec_lat_chk: assert property (@(posedge clk) disable iff (rst)
      dec_vi |=> dec_vo);
    // R1
    info_order_chk: assert property (@(posedge clk) disable iff (rst)
      enc_vi |=> enc_word[6:3] == $past(enc_data));
    // R6
    chk_flip_chk: assert property (@(posedge clk) disable iff (rst)
      (dec_vi && ($countones(dec_word[2:0] ^ {^{dec_word[6:4]}, dec_word[6] ^ dec_word[5] ^ dec_word[3],
        dec_word[6] ^ dec_word[4] ^ dec_word[3]}) == 1))
      |=> dec_data == $past(dec_word[6:3]));
    // R10
    dec_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(dec_vi)) |-> $stable(dec_data));
  end
endmodule

bind sec74_codec sec74_codec_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .enc_vi   (enc_vi),
  .enc_data (enc_data),
  .enc_vo   (enc_vo),
  .enc_word (enc_word),
  .dec_vi   (dec_vi),
  .dec_word (dec_word),
  .dec_vo   (dec_vo),
  .dec_data (dec_data),
  .dec_err  (dec_err),
  .dec_syn  (dec_syn)
);

// File: tb/sim_sec74_codec.sv
module sim_sec74_codec;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 50000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enc_vi = 1'b0;
  logic [3:0] enc_data = '0;
  logic       enc_vo;
  logic [6:0] enc_word;
  logic       dec_vi = 1'b0;
  logic [6:0] dec_word = '0;
  logic       dec_vo;
  logic [3:0] dec_data;
  logic       dec_err;
  logic [2:0] dec_syn;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec74_codec u0 (
    .clk(clk), .rst(rst),
    .enc_vi(enc_vi), .enc_data(enc_data), .enc_vo(enc_vo), .enc_word(enc_word),
    .dec_vi(dec_vi), .dec_word(dec_word), .dec_vo(dec_vo),
    .dec_data(dec_data), .dec_err(dec_err), .dec_syn(dec_syn)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_CYCLES && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WD_CYCLES);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference codeword from the parity rules of R1..R4.
  function automatic logic [6:0] ref_enc(input logic [3:0] d);
    return {d, d[3] ^ d[2] ^ d[1], d[3] ^ d[2] ^ d[0], d[3] ^ d[1] ^ d[0]};
  endfunction

  // Syndrome expected for a flip at word bit p (R6, R7).
  function automatic logic [2:0] ref_syn(input int p);
    case (p)
      0: return 3'b001;
      1: return 3'b010;
      2: return 3'b100;
      3: return 3'b011;
      4: return 3'b101;
      5: return 3'b110;
      default: return 3'b111;
    endcase
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    @(negedge clk);
    enc_vi = 1'b1; enc_data = 4'hF;
    dec_vi = 1'b1; dec_word = 7'h01;
    @(negedge clk);
    chk("R9 enc_vo", enc_vo, 0);
    chk("R9 enc_word", enc_word, 0);
    chk("R9 dec_vo", dec_vo, 0);
    chk("R9 dec_data", dec_data, 0);
    chk("R9 dec_err", dec_err, 0);
    chk("R9 dec_syn", dec_syn, 0);
    enc_vi = 1'b0; dec_vi = 1'b0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_encode_all();
    for (int d = 0; d < 16; d++) begin
      logic [6:0] w;
      w = ref_enc(4'(d));
      enc_vi = 1'b1; enc_data = 4'(d);
      @(negedge clk);
      chk("R1 info bits", enc_word[6:3], d);
      chk("R2 bit2", enc_word[2], w[2]);
      chk("R3 bit1", enc_word[1], w[1]);
      chk("R4 bit0", enc_word[0], w[0]);
    end
    enc_vi = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_decode_clean();
    for (int d = 0; d < 16; d++) begin
      dec_vi = 1'b1; dec_word = ref_enc(4'(d));
      @(negedge clk);
      chk("R5 syn", dec_syn, 0);
      chk("R5 err", dec_err, 0);
      chk("R5 data", dec_data, d);
    end
    dec_vi = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_decode_flip(input int lo, input int hi, input string req);
    for (int d = 0; d < 16; d++) begin
      for (int p = lo; p <= hi; p++) begin
        dec_vi = 1'b1; dec_word = ref_enc(4'(d)) ^ (7'd1 << p);
        @(negedge clk);
        chk({req, " syn"}, dec_syn, ref_syn(p));
        chk({req, " err"}, dec_err, 1);
        chk({req, " data"}, dec_data, d);
      end
    end
    dec_vi = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_latency();
    @(negedge clk);
    chk("R8 enc idle", enc_vo, 0);
    chk("R8 dec idle", dec_vo, 0);
    enc_vi = 1'b1; enc_data = 4'hA;
    dec_vi = 1'b1; dec_word = ref_enc(4'h6) ^ 7'h40;
    chk("R8 enc not yet", enc_vo, 0);
    chk("R8 dec not yet", dec_vo, 0);
    @(negedge clk);
    chk("R8 enc vo", enc_vo, 1);
    chk("R8 enc word", enc_word, ref_enc(4'hA));
    chk("R8 dec vo", dec_vo, 1);
    chk("R8 dec data", dec_data, 4'h6);
    enc_vi = 1'b0; dec_vi = 1'b0;
    @(negedge clk);
    chk("R8 enc drop", enc_vo, 0);
    chk("R8 dec drop", dec_vo, 0);
  endtask

  task automatic t_hold();
    enc_vi = 1'b1; enc_data = 4'h9;
    dec_vi = 1'b1; dec_word = ref_enc(4'h3) ^ 7'h02;
    @(negedge clk);
    enc_vi = 1'b0; enc_data = 4'h4;
    dec_vi = 1'b0; dec_word = ref_enc(4'hC) ^ 7'h10;
    @(negedge clk);
    @(negedge clk);
    chk("R10 enc word held", enc_word, ref_enc(4'h9));
    chk("R10 dec data held", dec_data, 4'h3);
    chk("R10 dec syn held", dec_syn, 3'b010);
    chk("R10 dec err held", dec_err, 1);
  endtask

  initial begin
    t_reset();
    t_encode_all();
    t_decode_clean();
    t_decode_flip(0, 2, "R6");
    t_decode_flip(3, 6, "R7");
    t_latency();
    t_hold();
    t_reset();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule